// File: doc/BRIEF.md
# DDR2 Device-Side Command Decoder

This block lets logic pose as a memory chip on a 16-bit DDR2-style bus. On every rising edge of the command clock it looks at chip select, the row and column strobes, write enable, the two bank bits and the address pins. It recognises three commands: bank activate, read and write. Every other pattern passes through without effect.

An activate stores the row on the address pins as the open row of the selected bank. Each of the four banks keeps its own open row. A read or write takes the open row of the bank it names, joins it with the bank number and the burst-aligned column, and gives one flat word address. The block then raises a single-cycle request that carries this address, the direction and the auto-precharge flag. Logic behind the block uses these requests to serve the access from its own storage. Precharge timing, refresh, mode registers and data-strobe capture are handled elsewhere.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: A bank activate is recognised when csN=0, rasN=0, casN=1 and weN=1 at a rising edge. It stores the address pins as the open row of bank `ba` and produces no request.
- R2: A read is recognised when csN=0, rasN=1, casN=0 and weN=1 at a rising edge. reqValid is high for the cycle after that edge, with reqWrite=0.
- R3: A write is recognised when csN=0, rasN=1, casN=0 and weN=0. It gives the same request as a read, but with reqWrite=1.
- R4: reqAddr is {row, bank, column}. The 13-bit row is in bits 24:12, the 2-bit bank in bits 11:10 and the 10-bit column in bits 9:0. The column comes from address pins 9:0.
- R5: reqAutoPre equals address pin 10 at the read or write command. Pin 10 never enters the column field.
- R6: The column is aligned to a 4-beat burst, so reqAddr bits 1:0 are always zero, whatever is on pins 1:0.
- R7: Each bank keeps its own open row. An access uses the last row activated in its bank, and an activate in one bank does not change the others.
- R8: No request is made and no row is changed by precharge (rasN=0, casN=1, weN=0), refresh (rasN=0, casN=0, weN=1), mode register set (all three low), no-operation (all three high), or any cycle with csN=1.
- R9: Each read or write gives exactly one single-cycle pulse. Back-to-back commands give back-to-back pulses in order.
- R10: After reset, reqValid is low and every bank's open row is zero.
- R11: With the ROW_PINS parameter set to 12, the address input is 12 bits wide and the top row bit of reqAddr is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; inputs sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank number |
| addr | input | ROW_PINS (13) | Row or column address pins; pin 10 is the auto-precharge flag on accesses |
| reqValid | output | 1 | Single-cycle access request strobe |
| reqAddr | output | 25 | Flat word address {row, bank, column} |
| reqWrite | output | 1 | 1 = write, 0 = read |
| reqAutoPre | output | 1 | Auto-precharge requested for this access |

## Verification
Two events can fall in the same cycle. One is a bank activate being sampled. The other is the request from the access just before it being presented with the old row of that same bank. The bench provokes this with a read of bank 0 followed at once by an activate of bank 0 with a new row, then a second read. The scoreboard expects the first request to carry the old row and the second to carry the new one, so a row table that updates too early or too late shows up as a wrong address.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  // strobes from command decode to the datapath
  typedef struct packed {
    logic actStb;  // bank activate this edge
    logic accStb;  // read or write this edge
    logic wrDir;   // 1 = write
  } cmdStb_t;
endpackage

// File: rtl/ddr_cmd_ctrl.sv
module ddr_cmd_ctrl
  import ddr_cmd_pkg::*;
(
  input  logic    csN,
  input  logic    rasN,
  input  logic    casN,
  input  logic    weN,
  output cmdStb_t stb
);
  typedef enum logic [2:0] {
    CMD_MRS  = 3'b000,
    CMD_REF  = 3'b001,
    CMD_PRE  = 3'b010,
    CMD_ACT  = 3'b011,
    CMD_WR   = 3'b100,
    CMD_RD   = 3'b101,
    CMD_BST  = 3'b110,
    CMD_NOP  = 3'b111
  } cmdCode_t;

  cmdCode_t code;

  always_comb begin
    code = cmdCode_t'({rasN, casN, weN});
    stb  = '0;
    if (!csN) begin
      unique case (code)
        CMD_ACT: stb.actStb = 1'b1;
        CMD_RD:  stb.accStb = 1'b1;
        CMD_WR:  begin stb.accStb = 1'b1; stb.wrDir = 1'b1; end
        default: stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/ddr_cmd_dpath.sv
module ddr_cmd_dpath
  import ddr_cmd_pkg::*;
#(
  parameter int ROW_W      = 13,
  parameter int ROW_PINS   = 13,
  parameter int COL_W      = 10,
  parameter int BANK_W     = 2,
  parameter int AP_BIT     = 10,
  parameter int BURST_LOG2 = 2,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int FLAT_W    = ROW_W + BANK_W + COL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  cmdStb_t             stb,
  input  logic [BANK_W-1:0]   ba,
  input  logic [ROW_PINS-1:0] addr,
  output logic                reqValid,
  output logic [FLAT_W-1:0]   reqAddr,
  output logic                reqWrite,
  output logic                reqAutoPre
);
  logic [ROW_W-1:0] rowIn;
  logic [ROW_W-1:0] rowTbl [NUM_BANKS];
  logic [COL_W-1:0] colAligned;

  generate
    if (ROW_PINS >= ROW_W) begin : g_fullRow
      assign rowIn = addr[ROW_W-1:0];
    end else begin : g_narrowRow
      assign rowIn = {{(ROW_W-ROW_PINS){1'b0}}, addr};
    end
  endgenerate

  assign colAligned = {addr[COL_W-1:BURST_LOG2], {BURST_LOG2{1'b0}}};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rowTbl[b] <= '0;
      else if (stb.actStb && ba == BANK_W'(b))
        rowTbl[b] <= rowIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid   <= 1'b0;
      reqAddr    <= '0;
      reqWrite   <= 1'b0;
      reqAutoPre <= 1'b0;
    end else begin
      reqValid <= stb.accStb;
      if (stb.accStb) begin
        reqAddr    <= {rowTbl[ba], ba, colAligned};
        reqWrite   <= stb.wrDir;
        reqAutoPre <= addr[AP_BIT];
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddr_cmd_pkg::*;
#(
  parameter int ROW_W      = 13,
  parameter int ROW_PINS   = 13,
  parameter int COL_W      = 10,
  parameter int BANK_W     = 2,
  parameter int AP_BIT     = 10,
  parameter int BURST_LOG2 = 2,
  localparam int FLAT_W    = ROW_W + BANK_W + COL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic [BANK_W-1:0]   ba,
  input  logic [ROW_PINS-1:0] addr,
  output logic                reqValid,
  output logic [FLAT_W-1:0]   reqAddr,
  output logic                reqWrite,
  output logic                reqAutoPre
);
  cmdStb_t stb;

  ddr_cmd_ctrl u_ctrl (
    .csN (csN),
    .rasN(rasN),
    .casN(casN),
    .weN (weN),
    .stb (stb)
  );

  ddr_cmd_dpath #(
    .ROW_W(ROW_W), .ROW_PINS(ROW_PINS), .COL_W(COL_W),
    .BANK_W(BANK_W), .AP_BIT(AP_BIT), .BURST_LOG2(BURST_LOG2)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ba        (ba),
    .addr      (addr),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqAutoPre(reqAutoPre)
  );
endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker #(
  parameter int ROW_W      = 13,
  parameter int ROW_PINS   = 13,
  parameter int COL_W      = 10,
  parameter int BANK_W     = 2,
  parameter int AP_BIT     = 10,
  parameter int BURST_LOG2 = 2,
  localparam int FLAT_W    = ROW_W + BANK_W + COL_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic                rasN,
  input logic                casN,
  input logic                weN,
  input logic [BANK_W-1:0]   ba,
  input logic [ROW_PINS-1:0] addr,
  input logic                reqValid,
  input logic [FLAT_W-1:0]   reqAddr,
  input logic                reqWrite,
  input logic                reqAutoPre
);
  AST_REQ_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(!csN && rasN && !casN)); // R2
  AST_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqWrite == !$past(weN))); // R3
  AST_BANK_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAddr[COL_W +: BANK_W] == $past(ba))); // R4
  AST_COL_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAddr[COL_W-1:BURST_LOG2] == $past(addr[COL_W-1:BURST_LOG2]))); // R4
  AST_AUTO_PRE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAutoPre == $past(addr[AP_BIT]))); // R5
  AST_BURST_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAddr[BURST_LOG2-1:0] == '0)); // R6
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> !reqValid); // R8
  AST_OTHER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rasN) |-> !reqValid); // R8
endmodule

bind ddr_cmd_decoder ddr_cmd_checker #(
  .ROW_W(ROW_W), .ROW_PINS(ROW_PINS), .COL_W(COL_W),
  .BANK_W(BANK_W), .AP_BIT(AP_BIT), .BURST_LOG2(BURST_LOG2)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .ba(ba), .addr(addr), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqWrite(reqWrite), .reqAutoPre(reqAutoPre)
);

// File: tb/ddr_cmd_decoder_test.sv
module ddr_cmd_decoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic        reqValid, reqWrite, reqAutoPre;
  logic [24:0] reqAddr;
  logic        nValid, nWrite, nAutoPre;
  logic [24:0] nAddr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [12:0] mRow [4];
  logic [24:0] qAddr [$];
  logic        qWr [$];
  logic        qAp [$];
  string       qTag [$];

  always #5 clk = ~clk;

  ddr_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqAutoPre(reqAutoPre)
  );

  ddr_cmd_decoder #(.ROW_PINS(12)) uutNarrow (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr[11:0]), .reqValid(nValid), .reqAddr(nAddr),
    .reqWrite(nWrite), .reqAutoPre(nAutoPre)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                       input logic [1:0] b, input logic [12:0] a);
    @(negedge clk);
    csN = c; rasN = r; casN = ca; weN = w; ba = b; addr = a;
  endtask

  task automatic doAct(input logic [1:0] b, input logic [12:0] row);
    drive(1'b0, 1'b0, 1'b1, 1'b1, b, row);
    mRow[b] = row;
  endtask

  task automatic doAcc(input logic [1:0] b, input logic [9:0] col, input logic wr,
                       input logic ap, input string tag);
    drive(1'b0, 1'b1, 1'b0, ~wr, b, {2'b00, ap, col});
    qAddr.push_back({mRow[b], b, col[9:2], 2'b00});
    qWr.push_back(wr);
    qAp.push_back(ap);
    qTag.push_back(tag);
  endtask

  task automatic doNop();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 13'h0);
  endtask

  // monitor: pops expected items as requests appear
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (reqValid) begin
        if (qAddr.size() == 0) begin
          check("R8 unexpected request", 32'd1, 32'd0);
        end else begin
          logic [24:0] ea;
          string t;
          ea = qAddr.pop_front();
          t  = qTag.pop_front();
          check({t, " addr"}, 32'(reqAddr), 32'(ea));
          check({t, " dir R3"}, 32'(reqWrite), 32'(qWr[0]));
          check({t, " autopre R5"}, 32'(reqAutoPre), 32'(qAp[0]));
          check("R11 narrow addr", 32'(nAddr), 32'({1'b0, ea[23:0]}));
          check("R11 narrow valid", 32'(nValid), 32'd1);
          void'(qWr.pop_front());
          void'(qAp.pop_front());
        end
      end else begin
        if (nValid) check("R11 narrow stray valid", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mRow[i] = '0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", 32'(reqValid), 32'd0);
    rstN = 1'b1;
    doNop();
    // R10: no activate yet, row reads as zero
    doAcc(2'd2, 10'h0F0, 1'b0, 1'b0, "R10 row zero");
    // R1 activates, R7 independent banks
    doAct(2'd0, 13'h1ABC);
    doAct(2'd1, 13'h0123);
    doAct(2'd2, 13'h1FFF);
    doAct(2'd3, 13'h0555);
    doAcc(2'd0, 10'h018, 1'b1, 1'b0, "R1 R3 R4 write bank0");
    doAcc(2'd1, 10'h01C, 1'b0, 1'b1, "R2 R5 read bank1");
    doAcc(2'd2, 10'h3FF, 1'b0, 1'b0, "R6 align");
    doAcc(2'd3, 10'h2A7, 1'b1, 1'b1, "R6 R7 bank3");
    // R9: back-to-back pulses
    doAcc(2'd1, 10'h004, 1'b1, 1'b0, "R9 b2b a");
    doAcc(2'd1, 10'h008, 1'b0, 1'b1, "R9 b2b b");
    doAcc(2'd2, 10'h00C, 1'b1, 1'b0, "R9 b2b c");
    // same-cycle case: request presented while bank0 re-activated
    doAcc(2'd0, 10'h040, 1'b0, 1'b0, "R7 old row");
    doAct(2'd0, 13'h0A5A);
    doAcc(2'd0, 10'h044, 1'b0, 1'b0, "R7 new row");
    doAcc(2'd3, 10'h100, 1'b0, 1'b0, "R7 other bank kept");
    // R8: ignored patterns
    drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 13'h1111); // precharge
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 13'h1222); // refresh
    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 13'h1333); // mode set
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 13'h1444); // nop
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 13'h1555); // deselected activate
    drive(1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 13'h0010); // deselected read
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 13'h0020); // deselected write
    doNop();
    doNop();
    check("R8 no pulse after ignored", 32'(reqValid), 32'd0);
    doAcc(2'd1, 10'h080, 1'b0, 1'b0, "R8 row kept bank1");
    doAcc(2'd2, 10'h084, 1'b1, 1'b0, "R8 row kept bank2");
    doNop();
    repeat (4) @(negedge clk);
    check("R9 all requests seen", 32'(qAddr.size()), 32'd0);
    check("R9 single pulse", 32'(reqValid), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule